// File: doc/BRIEF.md
# Message Fragmenting Transmitter

This block pushes a byte message of any length up to 2^LEN_W−1 to a numbered client through a circular buffer organised in 32-bit slots. It cuts the message into fragments. Each fragment is written as one header slot followed by its payload, packed four bytes to a slot. After the last slot of each fragment it raises a one-cycle doorbell. The block fetches payload bytes through an address output, so a retry can replay the message from byte 0.

A fragment carries at most min(4·depth, 511) − 4 payload bytes. The 511 bound comes from the 9-bit length field, and 4 bytes are kept back for the header slot. Only the fragment that empties the message carries the completion flag. If the peer's ready flag is low when a doorbell is raised, or if any wait runs past a programmable cycle budget, the attempt is dropped and the whole message starts again. After five failed attempts the block reports failure.

Top module: `msg_frag_tx`

## Requirements
- R1: After reset, and whenever no message is in flight, `slot_we_o`, `doorbell_o`, `done_o`, `fail_o` and `busy_o` are low.
- R2: A start with `msg_len_i` = 0 pulses `fail_o` on the next cycle and writes no slot.
- R3: The header slot holds: bit 31 = last-fragment flag, bits 30:25 = 0, bits 24:16 = fragment byte count, bits 15:8 = host address, bits 7:0 = client address.
- R4: Fragments carry min(min(4·depth_i, 511) − 4, bytes left) bytes each, in message order, and together they cover the message exactly.
- R5: The last-fragment flag is 1 only in the header of the fragment that carries the final byte.
- R6: The header is written only once `free_i` ≥ 1. The payload is written only once `free_i` ≥ ceil(count/4). While these conditions do not hold, no slot is written.
- R7: Payload is packed little-endian: byte k of a fragment goes to slot k/4, bits 8·(k mod 4)+7 : 8·(k mod 4). A partial last slot is zero-filled, giving ceil(count/4) payload slots.
- R8: `doorbell_o` pulses for one cycle, on the cycle after the last payload slot of each fragment.
- R9: If `ready_i` is low in the cycle after a fragment's last slot, the attempt fails. The next attempt waits for `ready_i` and resends the message from byte 0.
- R10: `done_o` pulses together with the final doorbell when every fragment succeeds. After 5 failed attempts, `fail_o` pulses instead. `done_o` and `fail_o` never pulse together.
- R11: Any wait (ready, header room, payload room) that lasts `timeout_i` cycles without its condition holding aborts the current attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a message (sampled while idle) |
| msg_len_i | input | LEN_W | Message length in bytes |
| host_addr_i | input | 8 | Host address placed in headers |
| client_addr_i | input | 8 | Client address placed in headers |
| depth_i | input | DEPTH_W | Circular buffer size in slots |
| free_i | input | DEPTH_W | Currently free slots |
| ready_i | input | 1 | Peer ready flag |
| timeout_i | input | TMO_W | Cycle budget for each wait |
| byte_addr_o | output | LEN_W | Message byte index being fetched |
| byte_i | input | 8 | Message byte at `byte_addr_o` (same cycle) |
| slot_we_o | output | 1 | Slot write strobe |
| slot_data_o | output | 32 | Slot write data |
| doorbell_o | output | 1 | Interrupt-generate pulse after each fragment |
| done_o | output | 1 | Message delivered |
| fail_o | output | 1 | Message abandoned |
| busy_o | output | 1 | Message in flight |

## Verification
The bench keeps the default widths (LEN_W = 16, DEPTH_W = 8) and five attempts. It drives `depth_i` at 3, 8 and 130. Depths 3 and 8 make the buffer the binding limit, including a message that exactly fills one fragment. Depth 130 lifts the buffer above the 9-bit field, so the 507-byte cap applies and a 600-byte message splits into a full fragment and a remainder. A budget of 8 cycles with no free room keeps the five aborted attempts short. Dropping ready at chosen doorbells exercises both one retry and exhaustion of all attempts.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int FLD_W   = 9;                    // header length field
  localparam int FLD_MAX = (1 << FLD_W) - 1;
  localparam int HDR_PAD = 32 - 1 - FLD_W - 16;

  typedef enum logic [2:0] {
    S_IDLE, S_WRDY, S_WHDR, S_WBODY, S_FETCH, S_RING
  } tx_state_e;
endpackage

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || expired_o)  cnt_q <= '0;
    else                          cnt_q <= cnt_q + W'(1);
endmodule

// File: rtl/frag_sizer.sv
module frag_sizer
  import frag_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int DEPTH_W = 8
) (
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [LEN_W-1:0]   rem_i,
  output logic [FLD_W-1:0]   flen_o,
  output logic               last_o
);
  logic [LEN_W-1:0] room, lim, cap;

  always_comb begin
    room   = LEN_W'({depth_i, 2'b00});
    lim    = (room > LEN_W'(FLD_MAX)) ? LEN_W'(FLD_MAX) : room;
    cap    = lim - LEN_W'(4);                      // header slot kept back
    last_o = (rem_i <= cap);
    flen_o = last_o ? rem_i[FLD_W-1:0] : cap[FLD_W-1:0];
  end
endmodule

// File: rtl/slot_packer.sv
module slot_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  logic        flush_i,
  input  logic [1:0]  lane_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o
);
  logic [31:0] acc_q;

  assign word_o = acc_q | ({24'b0, byte_i} << {lane_i, 3'b000});

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     acc_q <= '0;
    else if (take_i) acc_q <= flush_i ? 32'b0 : word_o;
endmodule

// File: rtl/msg_frag_tx.sv
module msg_frag_tx
  import frag_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int DEPTH_W = 8,
  parameter int TMO_W   = 16,
  parameter int MAX_TRY = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   msg_len_i,
  input  logic [7:0]         host_addr_i,
  input  logic [7:0]         client_addr_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [DEPTH_W-1:0] free_i,
  input  logic               ready_i,
  input  logic [TMO_W-1:0]   timeout_i,
  output logic [LEN_W-1:0]   byte_addr_o,
  input  logic [7:0]         byte_i,
  output logic               slot_we_o,
  output logic [31:0]        slot_data_o,
  output logic               doorbell_o,
  output logic               done_o,
  output logic               fail_o,
  output logic               busy_o
);
  localparam int TRY_W = $clog2(MAX_TRY + 1);

  tx_state_e        state_q;
  logic [LEN_W-1:0] len_q, off_q, rem_q;
  logic [7:0]       host_q, client_q;
  logic [TRY_W-1:0] tries_q;
  logic [FLD_W-1:0] flen_q, bi_q, nx_flen;
  logic             last_q, nx_last;
  logic             slot_we_q, db_q, done_q, fail_q;
  logic [31:0]      slot_data_q, packed_w;
  logic [FLD_W:0]   nsl;
  logic             hdr_ok, body_ok, waiting, expired, abort;
  logic             fetch, byte_last, flush;

  frag_sizer #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W)) u_size (
    .depth_i(depth_i), .rem_i(rem_q), .flen_o(nx_flen), .last_o(nx_last)
  );

  assign fetch     = (state_q == S_FETCH);
  assign byte_last = (bi_q == flen_q - FLD_W'(1));
  assign flush     = (bi_q[1:0] == 2'd3) || byte_last;

  slot_packer u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(fetch), .flush_i(flush),
    .lane_i(bi_q[1:0]), .byte_i(byte_i), .word_o(packed_w)
  );

  always_comb begin
    nsl     = ({1'b0, flen_q} + (FLD_W+1)'(3)) >> 2;
    hdr_ok  = (free_i != '0);
    body_ok = (LEN_W'(free_i) >= LEN_W'(nsl));
    waiting = ((state_q == S_WRDY)  && !ready_i) ||
              ((state_q == S_WHDR)  && !hdr_ok)  ||
              ((state_q == S_WBODY) && !body_ok);
    abort   = expired || ((state_q == S_RING) && !ready_i);
  end

  wait_timer #(.W(TMO_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(waiting),
    .limit_i(timeout_i), .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;   len_q <= '0;  off_q <= '0;  rem_q <= '0;
      host_q  <= '0;       client_q <= '0; tries_q <= '0;
      flen_q  <= '0;       bi_q <= '0;   last_q <= 1'b0;
      slot_we_q <= 1'b0;   slot_data_q <= '0;
      db_q <= 1'b0;        done_q <= 1'b0; fail_q <= 1'b0;
    end else begin
      slot_we_q <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      db_q      <= (state_q == S_RING);
      if (abort) begin
        if (tries_q == TRY_W'(MAX_TRY - 1)) begin
          fail_q  <= 1'b1;
          state_q <= S_IDLE;
        end else begin
          tries_q <= tries_q + TRY_W'(1);
          off_q   <= '0;
          rem_q   <= len_q;
          state_q <= S_WRDY;
        end
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i) begin
            len_q    <= msg_len_i;
            rem_q    <= msg_len_i;
            off_q    <= '0;
            host_q   <= host_addr_i;
            client_q <= client_addr_i;
            tries_q  <= '0;
            if (msg_len_i == '0) fail_q  <= 1'b1;
            else                 state_q <= S_WRDY;
          end
          S_WRDY: if (ready_i) state_q <= S_WHDR;
          S_WHDR: if (hdr_ok) begin
            slot_we_q   <= 1'b1;
            slot_data_q <= {nx_last, HDR_PAD'(0), nx_flen, host_q, client_q};
            flen_q      <= nx_flen;
            last_q      <= nx_last;
            state_q     <= S_WBODY;
          end
          S_WBODY: if (body_ok) begin
            bi_q    <= '0;
            state_q <= S_FETCH;
          end
          S_FETCH: begin
            bi_q <= bi_q + FLD_W'(1);
            if (flush) begin
              slot_we_q   <= 1'b1;
              slot_data_q <= packed_w;
            end
            if (byte_last) state_q <= S_RING;
          end
          S_RING: begin
            off_q <= off_q + LEN_W'(flen_q);
            rem_q <= rem_q - LEN_W'(flen_q);
            if (last_q) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_WHDR;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign byte_addr_o = off_q + LEN_W'(bi_q);
  assign slot_we_o   = slot_we_q;
  assign slot_data_o = slot_data_q;
  assign doorbell_o  = db_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign busy_o      = (state_q != S_IDLE);
endmodule

// File: rtl/frag_tx_chk.sv
module frag_tx_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] msg_len_i,
  input logic             slot_we_o,
  input logic             doorbell_o,
  input logic             done_o,
  input logic             fail_o,
  input logic             busy_o
);
  a_r1_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_we_o |-> busy_o);

  a_r2_zero_len_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && msg_len_i == '0) |=> (fail_o && !slot_we_o));

  a_r8_db_follows_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_o |-> $past(slot_we_o));

  a_r8_db_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_o |=> !doorbell_o);

  a_r10_done_has_db: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> doorbell_o);

  a_r10_done_fail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
endmodule

bind msg_frag_tx frag_tx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .msg_len_i(msg_len_i),
  .slot_we_o(slot_we_o), .doorbell_o(doorbell_o), .done_o(done_o),
  .fail_o(fail_o), .busy_o(busy_o)
);

// File: tb/sim_msg_frag_tx.sv
module sim_msg_frag_tx;
  localparam int LEN_W = 16, DEPTH_W = 8, TMO_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               start = 1'b0;
  logic [LEN_W-1:0]   msg_len = '0;
  logic [7:0]         host = '0, client = '0;
  logic [DEPTH_W-1:0] depth = 8'd8, free = '0;
  logic               ready_base = 1'b1, drop_q = 1'b0;
  logic [TMO_W-1:0]   tmo = 16'd1000;
  logic [LEN_W-1:0]   byte_addr_o;
  logic [7:0]         byte_i;
  logic               slot_we_o, doorbell_o, done_o, fail_o, busy_o;
  logic [31:0]        slot_data_o;

  int checks = 0, errors = 0, slot_cnt = 0, drop_left = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [7:0] pat(input logic [LEN_W-1:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return m ^ a[15:8] ^ 8'h5a;
  endfunction

  assign byte_i = pat(byte_addr_o);

  msg_frag_tx #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W), .TMO_W(TMO_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msg_len_i(msg_len),
    .host_addr_i(host), .client_addr_i(client), .depth_i(depth),
    .free_i(free), .ready_i(ready_base & ~drop_q), .timeout_i(tmo),
    .byte_addr_o(byte_addr_o), .byte_i(byte_i), .slot_we_o(slot_we_o),
    .slot_data_o(slot_data_o), .doorbell_o(doorbell_o), .done_o(done_o),
    .fail_o(fail_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // kinds: 0 slot, 1 doorbell, 2 done, 3 fail
  task automatic push(input logic [1:0] k, input logic [31:0] d, input string t);
    exp_q.push_back({k, d});
    tag_q.push_back(t);
  endtask

  task automatic push_attempt(input int len, input logic [7:0] h, input logic [7:0] c,
                              input int dep);
    int cap, off, rem, fl;
    bit last;
    logic [31:0] w;
    cap = ((dep * 4 < 511) ? dep * 4 : 511) - 4;
    off = 0;
    rem = len;
    while (rem > 0) begin
      fl   = (rem < cap) ? rem : cap;
      last = (rem <= cap);
      push(2'd0, {last, 6'b0, fl[8:0], h, c}, "R3/R4/R5 header");
      for (int s = 0; s < (fl + 3) / 4; s++) begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (s * 4 + b < fl) w[8*b +: 8] = pat(LEN_W'(off + s * 4 + b));
        push(2'd0, w, "R7 payload");
      end
      push(2'd1, 32'd0, "R8 doorbell");
      off += fl;
      rem -= fl;
    end
  endtask

  task automatic observe(input logic [1:0] k, input logic [31:0] d);
    logic [33:0] e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected output: actual kind %0d data %h, expected nothing", k, d);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != {k, d}) begin
        errors++;
        $display("FAIL %s: actual kind %0d data %h expected kind %0d data %h",
                 t, k, d, e[33:32], e[31:0]);
      end
    end
  endtask

  // monitor: scoreboard compare plus ready drop at chosen fragment ends
  always @(negedge clk) begin
    if (drop_q) drop_q <= 1'b0;
    if (rst_n) begin
      if (slot_we_o) begin
        slot_cnt++;
        observe(2'd0, slot_data_o);
        if (drop_left > 0 && slot_cnt % 3 == 0) begin
          drop_q <= 1'b1;
          drop_left--;
        end
      end
      if (doorbell_o) observe(2'd1, 32'd0);
      if (done_o)     observe(2'd2, 32'd0);
      if (fail_o)     observe(2'd3, 32'd0);
    end
  end

  task automatic run(input int len, input logic [7:0] h, input logic [7:0] c,
                     input string req, output int n);
    @(negedge clk);
    msg_len = LEN_W'(len); host = h; client = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while ((exp_q.size() != 0 || busy_o) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && !busy_o, req, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({slot_we_o, doorbell_o, done_o, fail_o, busy_o} == 5'b0, "R1 reset outputs",
        int'({slot_we_o, doorbell_o, done_o, fail_o, busy_o}), 0);

    // R2 zero length
    slot_cnt = 0;
    push(2'd3, 32'd0, "R2 zero length fail");
    run(0, 8'h11, 8'h22, "R2 zero length", n);
    chk(slot_cnt == 0, "R2 no slot writes", slot_cnt, 0);

    free = 8'd255;
    // R3 R7 short message with padding
    push_attempt(5, 8'hA5, 8'h3C, 8);
    push(2'd2, 32'd0, "R10 done");
    run(5, 8'hA5, 8'h3C, "R3 short message", n);

    // R4 R5 three fragments, buffer-limited
    push_attempt(70, 8'h01, 8'hFE, 8);
    push(2'd2, 32'd0, "R10 done");
    run(70, 8'h01, 8'hFE, "R4 multi fragment", n);

    // R4 exactly one full fragment
    push_attempt(28, 8'h02, 8'h04, 8);
    push(2'd2, 32'd0, "R10 done");
    run(28, 8'h02, 8'h04, "R4 exact fit", n);

    // R4 small depth
    depth = 8'd3;
    push_attempt(9, 8'h33, 8'h44, 3);
    push(2'd2, 32'd0, "R10 done");
    run(9, 8'h33, 8'h44, "R4 depth 3", n);

    // R4 length-field limit
    depth = 8'd130;
    push_attempt(600, 8'h7E, 8'h81, 130);
    push(2'd2, 32'd0, "R10 done");
    run(600, 8'h7E, 8'h81, "R4 field cap", n);

    // R6 stall on payload room
    depth = 8'd8;
    free  = 8'd1;
    slot_cnt = 0;
    push_attempt(5, 8'h55, 8'h66, 8);
    push(2'd2, 32'd0, "R10 done");
    @(negedge clk);
    msg_len = 16'd5; host = 8'h55; client = 8'h66; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(slot_cnt == 1, "R6 header only while room short", slot_cnt, 1);
    free = 8'd2;
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0 && !busy_o, "R6 resumes", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();

    // R9 ready drop on first doorbell -> one retry
    free = 8'd255;
    slot_cnt = 0;
    drop_left = 1;
    push_attempt(5, 8'h12, 8'h34, 8);
    push_attempt(5, 8'h12, 8'h34, 8);
    push(2'd2, 32'd0, "R9 done after retry");
    run(5, 8'h12, 8'h34, "R9 retry", n);
    chk(slot_cnt == 6, "R9 resend from byte 0", slot_cnt, 6);

    // R10 every attempt fails
    slot_cnt = 0;
    drop_left = 5;
    for (int a = 0; a < 5; a++) push_attempt(5, 8'h9A, 8'hBC, 8);
    push(2'd3, 32'd0, "R10 fail after five attempts");
    run(5, 8'h9A, 8'hBC, "R10 exhaustion", n);
    chk(slot_cnt == 15, "R10 five attempts", slot_cnt, 15);
    drop_left = 0;

    // R11 timeout on header room
    free = 8'd0;
    tmo  = 16'd8;
    slot_cnt = 0;
    push(2'd3, 32'd0, "R11 timeout fail");
    run(5, 8'h01, 8'h02, "R11 timeout", n);
    chk(slot_cnt == 0, "R11 no writes", slot_cnt, 0);
    chk(n >= 40, "R11 five budgets elapsed", n, 40);

    finish_run();
  end
endmodule